// File: doc/BRIEF.md
# Translation Entry Write Guard

This block sits in front of the final write of a translation-table update and rules on it. Each request gives the stage-2 permission of the page that holds the entry, the kind of agent doing the write, the entry as it stands now, the value the agent wants to write and, for a read-check-write, the value the agent expects to find. The guard answers one cycle later. The answer is one of three outcomes: a permission fault, a compare mismatch, or a write grant together with the entry to store.

The page permission has four modes: read-only, read-write, no-access, and a mostly-read-only mode. A mostly-read-only page refuses ordinary stores. It still accepts the hardware access-flag and dirty update, and it accepts the atomic read-check-write. When the current entry has its protected bit set, a read-check-write may change only a fixed set of permitted bit positions; every other bit keeps its old value. A separate assured-only page attribute refuses any write that would leave the entry without the protected bit.

Top module: `pte_write_guard`

## Requirements
- R1: The outputs are registered. `rsp_valid` is high exactly one cycle after each `req_valid` cycle. Reset clears `rsp_valid`, `rsp_fault`, `rsp_mismatch` and `rsp_write`.
- R2: `req_perm` encoding: 2'b00 read-only, 2'b01 read-write, 2'b10 mostly-read-only, 2'b11 no-access. Read-only and no-access fault on every source.
- R3: On a mostly-read-only page, an ordinary store (`req_src` 2'b00) faults.
- R4: On a mostly-read-only page, a hardware flag update (`req_src` 2'b01) and a read-check-write (`req_src` 2'b10) are accepted unless another rule refuses them.
- R5: A hardware flag update may differ from the old entry only in bit 10 (access flag) and bit 11 (dirty). Any other differing bit faults.
- R6: A read-check-write compares `old_entry` with `cmp_entry`. When they differ and no fault applies, the response shows `rsp_mismatch`=1, `rsp_fault`=0 and `rsp_write`=0.
- R7: For a read-check-write whose old entry has protected bit 52 set, the result is (old AND NOT mask) OR (new AND mask). The default mask is 64'h7800_0000_0000_0C00 and never includes bit 52.
- R8: For a store, a flag update, or a read-check-write on an unprotected entry, the granted result equals `new_entry`.
- R9: When `page_assured` is set, a write whose resulting entry has bit 52 clear faults.
- R10: Source code 2'b11 is reserved and always faults.
- R11: Each response carries exactly one of fault, mismatch or write. On a fault or a mismatch, `rsp_entry` equals the old entry. A fault takes precedence over a mismatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_perm | input | 2 | Stage-2 page permission mode |
| req_src | input | 2 | Write source: store, flag update, read-check-write, reserved |
| page_assured | input | 1 | Page accepts only protected entries |
| old_entry | input | 64 | Entry as currently held |
| new_entry | input | 64 | Requested new value |
| cmp_entry | input | 64 | Expected old value for read-check-write |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_fault | output | 1 | Permission fault |
| rsp_mismatch | output | 1 | Read-check-write compare failed |
| rsp_write | output | 1 | Write granted |
| rsp_entry | output | 64 | Entry value to store, or the old value when not granted |

## Verification
The bench builds the guard with its defaults: a 64-bit entry, protected bit 52, access flag at bit 10, dirty at bit 11, the permitted-field mask 64'h7800_0000_0000_0C00, and the compare stage enabled. With these values a merge can be checked in both directions, since bits inside the mask take the new value and bits outside it keep the old value. The same settings give the protected bit and the flag bits fixed positions, so a stray flag-update change and an assured-only violation show up as faults at the ports. Precedence between a fault and a compare mismatch is exercised directly.

// File: rtl/pwg_pkg.sv
package pwg_pkg;
   typedef enum logic [1:0] {
      SRC_STORE  = 2'b00,
      SRC_HWFLAG = 2'b01,
      SRC_RCW    = 2'b10,
      SRC_RSVD   = 2'b11
   } src_e;

   typedef enum logic [1:0] {
      PERM_RO   = 2'b00,
      PERM_RW   = 2'b01,
      PERM_MRO  = 2'b10,
      PERM_NONE = 2'b11
   } perm_e;
endpackage

// File: rtl/pwg_merge.sv
module pwg_merge #(
   parameter int             W    = 64,
   parameter logic [W-1:0]   MASK = '0
) (
   input  logic [W-1:0] cur_val,
   input  logic [W-1:0] req_val,
   input  logic         restrict_en,
   output logic [W-1:0] merged
);
   for (genvar b = 0; b < W; b++) begin : g_bit
      if (MASK[b]) begin : g_open
         assign merged[b] = req_val[b];
      end else begin : g_locked
         assign merged[b] = restrict_en ? cur_val[b] : req_val[b];
      end
   end
endmodule

// File: rtl/pwg_compare.sv
module pwg_compare #(
   parameter int W      = 64,
   parameter bit CMP_EN = 1'b1
) (
   input  logic [W-1:0] cur_val,
   input  logic [W-1:0] exp_val,
   output logic         match
);
   if (CMP_EN) begin : g_cmp
      assign match = (cur_val == exp_val);
   end else begin : g_nocmp
      logic [W-1:0] unused_x;
      assign unused_x = cur_val ^ exp_val;
      assign match    = 1'b1;
   end
endmodule

// File: rtl/pwg_perm_check.sv
module pwg_perm_check
   import pwg_pkg::*;
#(
   parameter int W         = 64,
   parameter int AF_POS    = 10,
   parameter int DIRTY_POS = 11,
   parameter int PROT_POS  = 52
) (
   input  perm_e        perm,
   input  src_e         src,
   input  logic [W-1:0] cur_val,
   input  logic [W-1:0] req_val,
   input  logic [W-1:0] result_val,
   input  logic         assured,
   output logic         fault
);
   localparam logic [W-1:0] ONE       = {{(W-1){1'b0}}, 1'b1};
   localparam logic [W-1:0] FLAG_BITS = (ONE << AF_POS) | (ONE << DIRTY_POS);

   logic perm_bad, flag_bad, assured_bad, src_bad;

   always_comb begin
      src_bad = (src == SRC_RSVD);
      unique case (perm)
         PERM_RO, PERM_NONE: perm_bad = 1'b1;
         PERM_MRO:           perm_bad = (src == SRC_STORE);
         default:            perm_bad = 1'b0;
      endcase
      flag_bad    = (src == SRC_HWFLAG) && (((cur_val ^ req_val) & ~FLAG_BITS) != '0);
      assured_bad = assured && !result_val[PROT_POS];
      fault       = src_bad | perm_bad | flag_bad | assured_bad;
   end
endmodule

// File: rtl/pte_write_guard.sv
module pte_write_guard
   import pwg_pkg::*;
#(
   parameter int                   ENTRY_W    = 64,
   parameter int                   PROT_POS   = 52,
   parameter int                   AF_POS     = 10,
   parameter int                   DIRTY_POS  = 11,
   parameter logic [ENTRY_W-1:0]   FIELD_MASK = 64'h7800_0000_0000_0C00,
   parameter bit                   RCW_COMPARE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [1:0]         req_perm,
   input  logic [1:0]         req_src,
   input  logic               page_assured,
   input  logic [ENTRY_W-1:0] old_entry,
   input  logic [ENTRY_W-1:0] new_entry,
   input  logic [ENTRY_W-1:0] cmp_entry,
   output logic               rsp_valid,
   output logic               rsp_fault,
   output logic               rsp_mismatch,
   output logic               rsp_write,
   output logic [ENTRY_W-1:0] rsp_entry
);
   if (PROT_POS >= ENTRY_W || AF_POS >= ENTRY_W || DIRTY_POS >= ENTRY_W) begin : g_bad_pos
      $error("pte_write_guard: bit position outside entry");
   end
   if (AF_POS == DIRTY_POS || AF_POS == PROT_POS || DIRTY_POS == PROT_POS) begin : g_bad_overlap
      $error("pte_write_guard: flag and protected positions must differ");
   end
   if (FIELD_MASK[PROT_POS]) begin : g_bad_mask
      $error("pte_write_guard: permitted mask may not open the protected bit");
   end

   src_e  src_c;
   perm_e perm_c;
   assign src_c  = src_e'(req_src);
   assign perm_c = perm_e'(req_perm);

   logic               restrict_c;
   logic [ENTRY_W-1:0] merged_c;
   logic               match_c;
   logic               fault_c;
   logic               mismatch_c;

   assign restrict_c = (src_c == SRC_RCW) && old_entry[PROT_POS];

   pwg_merge #(.W(ENTRY_W), .MASK(FIELD_MASK)) u_merge (
      .cur_val     (old_entry),
      .req_val     (new_entry),
      .restrict_en (restrict_c),
      .merged      (merged_c)
   );

   pwg_compare #(.W(ENTRY_W), .CMP_EN(RCW_COMPARE)) u_cmp (
      .cur_val (old_entry),
      .exp_val (cmp_entry),
      .match   (match_c)
   );

   pwg_perm_check #(
      .W(ENTRY_W), .AF_POS(AF_POS), .DIRTY_POS(DIRTY_POS), .PROT_POS(PROT_POS)
   ) u_perm (
      .perm       (perm_c),
      .src        (src_c),
      .cur_val    (old_entry),
      .req_val    (new_entry),
      .result_val (merged_c),
      .assured    (page_assured),
      .fault      (fault_c)
   );

   assign mismatch_c = (src_c == SRC_RCW) && !match_c && !fault_c;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_fault    <= 1'b0;
         rsp_mismatch <= 1'b0;
         rsp_write    <= 1'b0;
         rsp_entry    <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_fault    <= fault_c;
            rsp_mismatch <= mismatch_c;
            rsp_write    <= !fault_c && !mismatch_c;
            rsp_entry    <= (fault_c || mismatch_c) ? old_entry : merged_c;
         end else begin
            rsp_fault    <= 1'b0;
            rsp_mismatch <= 1'b0;
            rsp_write    <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/pte_write_guard_chk.sv
module pte_write_guard_chk #(
   parameter int                   ENTRY_W    = 64,
   parameter int                   PROT_POS   = 52,
   parameter int                   AF_POS     = 10,
   parameter int                   DIRTY_POS  = 11,
   parameter logic [ENTRY_W-1:0]   FIELD_MASK = 64'h7800_0000_0000_0C00
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic [1:0]         req_perm,
   input logic [1:0]         req_src,
   input logic               page_assured,
   input logic [ENTRY_W-1:0] old_entry,
   input logic [ENTRY_W-1:0] new_entry,
   input logic [ENTRY_W-1:0] cmp_entry,
   input logic               rsp_valid,
   input logic               rsp_fault,
   input logic               rsp_mismatch,
   input logic               rsp_write,
   input logic [ENTRY_W-1:0] rsp_entry
);
   localparam logic [ENTRY_W-1:0] ONE   = {{(ENTRY_W-1){1'b0}}, 1'b1};
   localparam logic [ENTRY_W-1:0] FLAGS = (ONE << AF_POS) | (ONE << DIRTY_POS);

   logic [ENTRY_W-1:0] unused_in;
   assign unused_in = new_entry ^ cmp_entry;

   assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   assert_no_spurious_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   assert_mro_store_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_perm == 2'b10 && req_src == 2'b00) |=> rsp_fault);
   assert_flag_update_narrow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_write && $past(req_src) == 2'b01) |->
         (((rsp_entry ^ $past(old_entry)) & ~FLAGS) == '0));
   assert_protected_fields_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_write && $past(req_src) == 2'b10 && $past(old_entry[PROT_POS])) |->
         (((rsp_entry ^ $past(old_entry)) & ~FIELD_MASK) == '0));
   assert_assured_keeps_prot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_write && $past(page_assured)) |-> rsp_entry[PROT_POS]);
   assert_reserved_src_fault_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_src == 2'b11) |=> rsp_fault);
   assert_one_outcome_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> ($countones({rsp_fault, rsp_mismatch, rsp_write}) == 1));
   assert_idle_no_outcome_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> !(rsp_fault || rsp_mismatch || rsp_write));
   assert_refused_keeps_old_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_fault || rsp_mismatch) |-> (rsp_entry == $past(old_entry)));
endmodule

bind pte_write_guard pte_write_guard_chk #(
   .ENTRY_W(ENTRY_W), .PROT_POS(PROT_POS), .AF_POS(AF_POS),
   .DIRTY_POS(DIRTY_POS), .FIELD_MASK(FIELD_MASK)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_perm(req_perm),
   .req_src(req_src), .page_assured(page_assured), .old_entry(old_entry),
   .new_entry(new_entry), .cmp_entry(cmp_entry), .rsp_valid(rsp_valid),
   .rsp_fault(rsp_fault), .rsp_mismatch(rsp_mismatch), .rsp_write(rsp_write),
   .rsp_entry(rsp_entry)
);

// File: tb/pte_write_guard_bench.sv
module pte_write_guard_bench;
   localparam logic [63:0] PROT = 64'h0010_0000_0000_0000;
   localparam logic [63:0] AF   = 64'h0000_0000_0000_0400;
   localparam logic [63:0] DRTY = 64'h0000_0000_0000_0800;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_perm = 2'b00;
   logic [1:0]  req_src = 2'b00;
   logic        page_assured = 1'b0;
   logic [63:0] old_entry = '0;
   logic [63:0] new_entry = '0;
   logic [63:0] cmp_entry = '0;
   logic        rsp_valid, rsp_fault, rsp_mismatch, rsp_write;
   logic [63:0] rsp_entry;

   int total = 0;
   int bad = 0;

   always #2 clk = ~clk;

   pte_write_guard u_pte_write_guard (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_perm(req_perm),
      .req_src(req_src), .page_assured(page_assured), .old_entry(old_entry),
      .new_entry(new_entry), .cmp_entry(cmp_entry), .rsp_valid(rsp_valid),
      .rsp_fault(rsp_fault), .rsp_mismatch(rsp_mismatch), .rsp_write(rsp_write),
      .rsp_entry(rsp_entry)
   );

   task automatic chk_bit(input string tag, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   task automatic chk_word(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Issue one request, sample at the negedge after the registering edge.
   task automatic issue(input logic [1:0] perm, input logic [1:0] src, input logic asr,
                        input logic [63:0] o, input logic [63:0] n, input logic [63:0] c);
      @(negedge clk);
      req_valid = 1'b1; req_perm = perm; req_src = src; page_assured = asr;
      old_entry = o; new_entry = n; cmp_entry = c;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic expect_rsp(input string tag, input logic f, input logic m,
                             input logic [63:0] e);
      chk_bit({tag, " valid"}, rsp_valid, 1'b1);
      chk_bit({tag, " fault"}, rsp_fault, f);
      chk_bit({tag, " mismatch"}, rsp_mismatch, m);
      chk_bit({tag, " write"}, rsp_write, !f && !m);
      chk_word({tag, " entry"}, rsp_entry, e);
   endtask

   task automatic t_reset;
      chk_bit("R1 reset valid", rsp_valid, 1'b0);
      chk_bit("R1 reset fault", rsp_fault, 1'b0);
      chk_bit("R1 reset write", rsp_write, 1'b0);
   endtask

   task automatic t_timing;
      issue(2'b01, 2'b00, 1'b0, 64'h5, 64'h6, 64'h0);
      expect_rsp("R1 R8 rw store", 1'b0, 1'b0, 64'h6);
      @(negedge clk);
      chk_bit("R1 valid drops", rsp_valid, 1'b0);
      chk_bit("R1 write drops", rsp_write, 1'b0);
   endtask

   task automatic t_mro;
      issue(2'b10, 2'b00, 1'b0, 64'h1234, 64'h9999, 64'h0);
      expect_rsp("R3 mro store", 1'b1, 1'b0, 64'h1234);
      issue(2'b10, 2'b01, 1'b0, 64'h1234, 64'h1234 | AF | DRTY, 64'h0);
      expect_rsp("R4 R5 mro flag update", 1'b0, 1'b0, 64'h1234 | AF | DRTY);
      issue(2'b10, 2'b10, 1'b0, 64'hAA00, 64'h0F0F_0000_0000_00FF, 64'hAA00);
      expect_rsp("R4 R8 mro rcw unprotected", 1'b0, 1'b0, 64'h0F0F_0000_0000_00FF);
   endtask

   task automatic t_perm_modes;
      issue(2'b00, 2'b01, 1'b0, 64'h0, AF, 64'h0);
      expect_rsp("R2 read-only flag update", 1'b1, 1'b0, 64'h0);
      issue(2'b11, 2'b10, 1'b0, 64'h7, 64'h8, 64'h7);
      expect_rsp("R2 no-access rcw", 1'b1, 1'b0, 64'h7);
   endtask

   task automatic t_flag_bad;
      issue(2'b01, 2'b01, 1'b0, 64'h0, AF | 64'h20, 64'h0);
      expect_rsp("R5 flag update stray bit", 1'b1, 1'b0, 64'h0);
   endtask

   task automatic t_rcw_compare;
      issue(2'b01, 2'b10, 1'b0, 64'h100, 64'h200, 64'h101);
      expect_rsp("R6 rcw mismatch", 1'b0, 1'b1, 64'h100);
      issue(2'b00, 2'b10, 1'b0, 64'h100, 64'h200, 64'h101);
      expect_rsp("R11 fault over mismatch", 1'b1, 1'b0, 64'h100);
   endtask

   task automatic t_rcw_protected;
      issue(2'b01, 2'b10, 1'b0, PROT | 64'h1234, '1, PROT | 64'h1234);
      expect_rsp("R7 protected merge open", 1'b0, 1'b0, 64'h7810_0000_0000_1E34);
      issue(2'b10, 2'b10, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF);
      expect_rsp("R7 protected merge close", 1'b0, 1'b0, 64'h87FF_FFFF_FFFF_F3FF);
   endtask

   task automatic t_store_protected;
      issue(2'b01, 2'b00, 1'b0, PROT | 64'h1, 64'h3, 64'h0);
      expect_rsp("R8 store ignores protected", 1'b0, 1'b0, 64'h3);
   endtask

   task automatic t_assured;
      issue(2'b01, 2'b00, 1'b1, PROT, 64'h3, 64'h0);
      expect_rsp("R9 assured unprotected", 1'b1, 1'b0, PROT);
      issue(2'b01, 2'b00, 1'b1, 64'h0, PROT | 64'h3, 64'h0);
      expect_rsp("R9 assured protected", 1'b0, 1'b0, PROT | 64'h3);
      issue(2'b10, 2'b10, 1'b1, PROT, 64'h0, PROT);
      expect_rsp("R9 assured rcw keeps prot", 1'b0, 1'b0, PROT);
   endtask

   task automatic t_reserved;
      issue(2'b01, 2'b11, 1'b0, 64'h44, 64'h44, 64'h44);
      expect_rsp("R10 reserved source", 1'b1, 1'b0, 64'h44);
   endtask

   initial begin
      #(4 * 100000);
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_timing();
      t_mro();
      t_perm_modes();
      t_flag_bad();
      t_rcw_compare();
      t_rcw_protected();
      t_store_protected();
      t_assured();
      t_reserved();
      @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule